// File: doc/BRIEF.md
# Four-Phase Handshake Bus Master

This block moves one message per request across a simple parallel bus that uses a request line (`bus_ready`, driven here) and an acknowledge line (`bus_ack`, driven by the target). A local request supplies a channel address, a direction and a length in bytes. The engine splits the message into 32-bit words and runs one complete four-phase handshake for each word. During a write it fetches each word from a local word buffer through an index port. During a read it writes each captured word back through the same index.

The delay from driving the address to raising `bus_ready` is a cycle count, and so is the delay from seeing the acknowledge to dropping `bus_ready`. Both come from parameters and are clamped into their legal windows at elaboration. The acknowledge input goes through a two-flop synchroniser before the state machine uses it. A zero-length request moves no words and works as a bare synchronisation event. While `busy` is high, new requests are ignored.

Top module: `hs_bus_master`

## Requirements
- R1: While reset is held, and on the first cycle after it, `bus_ready`, `bus_doe`, `busy`, `done` and `buf_we` are low and `bus_addr` is zero.
- R2: `bus_ready` rises exactly S rising edges after the edge that drives a word's address. For the first word, that edge is the one that accepts the request. For later words, it is the third edge after `bus_ack` goes low. S is the effective setup count.
- R3: `bus_ready` falls on the (H+3)-th rising edge after `bus_ack` goes high. This is two synchroniser stages, one sampling edge, then H hold cycles, where H is the effective hold count.
- R4: The setup count is clamped into [5,15] cycles and the hold count into [10,25] cycles. A setup parameter of 1 acts as 5, and a hold parameter of 40 acts as 25.
- R5: During a write word, `bus_doe` is high from the address edge until the edge where `bus_ready` falls. Over that span, `bus_dout` holds the buffer word at index k, where k is the zero-based word number.
- R6: `req_rd`=1 selects receive. `bus_doe` then stays low, and on the third edge after `bus_ack` rises, `buf_we` pulses for one cycle. With that pulse, `buf_rdata` equals `bus_din` and `buf_idx` equals the word number.
- R7: A request of L>0 bytes produces exactly ceil(L/4) handshakes. The remaining count drops by 4 per word, and the message ends once the count reaches zero or below.
- R8: A zero-length request raises `done` for one cycle on the accepting edge. `bus_ready` never rises and `busy` stays low.
- R9: After the last word, `done` pulses for exactly one cycle on the third edge after `bus_ack` goes low. `busy` falls on that same edge.
- R10: A request presented while `busy` is high is ignored. It causes no extra handshake, and no change of address or direction.
- R11: `bus_addr` equals the requested channel for every word of the message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_chan | input | 16 | Channel address for the message |
| req_rd | input | 1 | 1 = receive, 0 = send |
| req_len | input | 12 | Message length in bytes |
| busy | output | 1 | Message in flight |
| done | output | 1 | One-cycle completion pulse |
| buf_idx | output | 10 | Word index into the local buffer |
| buf_wdata | input | 32 | Buffer word at `buf_idx` (send) |
| buf_we | output | 1 | Buffer write strobe (receive) |
| buf_rdata | output | 32 | Captured word to store (receive) |
| bus_addr | output | 16 | Bus address |
| bus_dout | output | 32 | Bus data driven by this master |
| bus_doe | output | 1 | Output enable for `bus_dout` |
| bus_din | input | 32 | Bus data from the target |
| bus_ready | output | 1 | Master handshake line |
| bus_ack | input | 1 | Target handshake line |

## Verification
The bench builds two copies of the block. The main copy uses a setup count of 6 and a hold count of 10. These are inside the legal windows, so the exact edge counts of R2, R3, R6 and R9 can be compared against fixed arithmetic across lengths that are multiples of four and lengths that are not, with varied target latencies. The second copy is built with a setup of 1 and a hold of 40. Both values are outside their windows, so the bench can observe the clamped timings of 5 and 25 at the ports.

// File: rtl/hs_bus_master.sv
module hs_bus_master #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 12,
  parameter int SETUP_CYC = 7,
  parameter int HOLD_CYC  = 12,
  parameter int SETUP_MIN = 5,
  parameter int SETUP_MAX = 15,
  parameter int HOLD_MIN  = 10,
  parameter int HOLD_MAX  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_chan,
  input  logic              req_rd,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              done,
  output logic [LEN_W-3:0]  buf_idx,
  input  logic [DATA_W-1:0] buf_wdata,
  output logic              buf_we,
  output logic [DATA_W-1:0] buf_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              bus_ready,
  input  logic              bus_ack
);

  localparam int IDX_W     = LEN_W - 2;
  localparam int SETUP_EFF = (SETUP_CYC < SETUP_MIN) ? SETUP_MIN :
                             (SETUP_CYC > SETUP_MAX) ? SETUP_MAX : SETUP_CYC;
  localparam int HOLD_EFF  = (HOLD_CYC < HOLD_MIN) ? HOLD_MIN :
                             (HOLD_CYC > HOLD_MAX) ? HOLD_MAX : HOLD_CYC;
  localparam int CNT_MAX   = (SETUP_MAX > HOLD_MAX) ? SETUP_MAX : HOLD_MAX;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_EFF - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_EFF - 1);
  localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(4);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_WAIT_HI, ST_HOLD, ST_WAIT_LO
  } state_t;

  state_t           state;
  logic [1:0]       ack_pipe;
  logic             ack_s;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W-1:0] rem;
  logic [IDX_W-1:0] idx;
  logic             rd_mode;

  assign ack_s   = ack_pipe[1];
  assign busy    = (state != ST_IDLE);
  assign buf_idx = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ack_pipe  <= '0;
      cnt       <= '0;
      rem       <= '0;
      idx       <= '0;
      rd_mode   <= 1'b0;
      done      <= 1'b0;
      buf_we    <= 1'b0;
      buf_rdata <= '0;
      bus_addr  <= '0;
      bus_dout  <= '0;
      bus_doe   <= 1'b0;
      bus_ready <= 1'b0;
    end else begin
      ack_pipe <= {ack_pipe[0], bus_ack};
      done     <= 1'b0;
      buf_we   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            bus_addr <= req_chan;
            rd_mode  <= req_rd;
            rem      <= req_len;
            idx      <= '0;
            cnt      <= '0;
            if (req_len == '0) begin
              done <= 1'b1;
            end else begin
              state    <= ST_SETUP;
              bus_dout <= req_rd ? '0 : buf_wdata;
              bus_doe  <= !req_rd;
            end
          end
        end
        ST_SETUP: begin
          if (cnt == SETUP_LAST) begin
            bus_ready <= 1'b1;
            cnt       <= '0;
            state     <= ST_WAIT_HI;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_WAIT_HI: begin
          if (ack_s) begin
            if (rd_mode) begin
              buf_rdata <= bus_din;
              buf_we    <= 1'b1;
            end
            cnt   <= '0;
            state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (cnt == HOLD_LAST) begin
            bus_ready <= 1'b0;
            bus_doe   <= 1'b0;
            idx       <= idx + IDX_W'(1);
            rem       <= (rem > WORD_BYTES) ? rem - WORD_BYTES : '0;
            cnt       <= '0;
            state     <= ST_WAIT_LO;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_WAIT_LO: begin
          if (!ack_s) begin
            if (rem == '0) begin
              done  <= 1'b1;
              idx   <= '0;
              state <= ST_IDLE;
            end else begin
              bus_dout <= rd_mode ? '0 : buf_wdata;
              bus_doe  <= !rd_mode;
              state    <= ST_SETUP;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic [7:0] chk_lo, chk_hi;
  localparam logic [7:0] SU8 = 8'(SETUP_EFF);
  localparam logic [7:0] HD8 = 8'(HOLD_EFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_lo <= '0;
      chk_hi <= '0;
    end else begin
      if (bus_ready || !busy) chk_lo <= '0;
      else if (chk_lo != 8'hFF) chk_lo <= chk_lo + 8'd1;
      if (!bus_ready) chk_hi <= '0;
      else if (ack_s && chk_hi != 8'hFF) chk_hi <= chk_hi + 8'd1;
    end
  end

  a_r2_setup_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ready) |-> chk_lo >= SU8);
  a_r3_hold_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ready) |-> chk_hi >= HD8);
  a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |-> $stable(bus_addr));
  a_r5_dout_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && bus_doe) |-> $stable(bus_dout));
  a_r6_capture_read: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (bus_ready && !bus_doe));
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/test_hs_bus_master.sv
module test_hs_bus_master;
  localparam int CLK_P = 10;
  localparam int A_SU = 6, A_HD = 10;
  localparam int B_SU = 1, B_HD = 40, B_SU_EFF = 5, B_HD_EFF = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic        a_req_valid = 0, a_req_rd = 0;
  logic [15:0] a_req_chan = 0;
  logic [11:0] a_req_len = 0;
  logic        a_busy, a_done, a_we, a_doe, a_ready;
  logic [9:0]  a_idx;
  logic [31:0] a_wdata, a_rdata, a_dout;
  logic [31:0] a_din = 0;
  logic [15:0] a_addr;
  logic        a_ack = 0;
  assign a_wdata = {16'hD00D, 6'h0, a_idx};

  hs_bus_master #(.SETUP_CYC(A_SU), .HOLD_CYC(A_HD)) i_hs_bus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(a_req_valid), .req_chan(a_req_chan),
    .req_rd(a_req_rd), .req_len(a_req_len), .busy(a_busy), .done(a_done),
    .buf_idx(a_idx), .buf_wdata(a_wdata), .buf_we(a_we), .buf_rdata(a_rdata),
    .bus_addr(a_addr), .bus_dout(a_dout), .bus_doe(a_doe), .bus_din(a_din),
    .bus_ready(a_ready), .bus_ack(a_ack));

  logic        b_req_valid = 0;
  logic        b_busy, b_done, b_we, b_doe, b_ready;
  logic [9:0]  b_idx;
  logic [31:0] b_wdata, b_rdata, b_dout;
  logic [15:0] b_addr;
  logic        b_ack = 0;
  assign b_wdata = {16'hB0B0, 6'h0, b_idx};

  hs_bus_master #(.SETUP_CYC(B_SU), .HOLD_CYC(B_HD)) i_hs_bus_master_clamp (
    .clk(clk), .rst_n(rst_n), .req_valid(b_req_valid), .req_chan(16'h0777),
    .req_rd(1'b0), .req_len(12'd4), .busy(b_busy), .done(b_done),
    .buf_idx(b_idx), .buf_wdata(b_wdata), .buf_we(b_we), .buf_rdata(b_rdata),
    .bus_addr(b_addr), .bus_dout(b_dout), .bus_doe(b_doe), .bus_din(32'h0),
    .bus_ready(b_ready), .bus_ack(b_ack));

  int          exp_rise = 0, words = 0, lat_hi = 0, lat_lo = 0;
  int          t_ack = 0, last_drop = 0, rd_cnt = 0;
  bit          cur_rd = 0;
  logic [15:0] cur_chan = 0;

  // target model for the main copy
  initial begin
    forever begin
      @(negedge clk iff a_ready);
      chk(cyc == exp_rise, "R2 setup edge", 32'(cyc), 32'(exp_rise));
      chk(a_addr == cur_chan, "R11 channel", 32'(a_addr), 32'(cur_chan));
      if (!cur_rd)
        chk(a_doe && a_dout == {16'hD00D, 6'h0, 10'(words)}, "R5 write word",
            a_dout, {16'hD00D, 6'h0, 10'(words)});
      else
        chk(!a_doe, "R6 no drive on read", 32'(a_doe), 32'd0);
      repeat (lat_hi) @(negedge clk);
      a_din = {16'hFACE, 6'h0, 10'(words)};
      a_ack = 1'b1;
      t_ack = cyc;
      @(negedge clk iff !a_ready);
      chk(cyc == t_ack + 3 + A_HD, "R3 hold edge", 32'(cyc), 32'(t_ack + 3 + A_HD));
      chk(!a_doe, "R5 enable off at ready fall", 32'(a_doe), 32'd0);
      words++;
      repeat (lat_lo) @(negedge clk);
      a_ack     = 1'b0;
      last_drop = cyc;
      exp_rise  = cyc + 3 + A_SU;
    end
  end

  always @(negedge clk) begin
    if (rst_n && a_we) begin
      chk(a_rdata == {16'hFACE, 6'h0, 10'(rd_cnt)}, "R6 read data", a_rdata, {16'hFACE, 6'h0, 10'(rd_cnt)});
      chk(a_idx == 10'(rd_cnt), "R6 read index", 32'(a_idx), 32'(rd_cnt));
      chk(cyc == t_ack + 3, "R6 capture edge", 32'(cyc), 32'(t_ack + 3));
      rd_cnt++;
    end
  end

  task automatic run_msg(input bit rd, input logic [15:0] chan, input logic [11:0] len,
                         input int lh, input int ll, input int exp_w, input bit intrude);
    int q, dc;
    bit seen;
    @(negedge clk);
    words = 0; rd_cnt = 0; cur_rd = rd; cur_chan = chan; lat_hi = lh; lat_lo = ll;
    a_req_valid = 1'b1; a_req_rd = rd; a_req_chan = chan; a_req_len = len;
    q = cyc;
    exp_rise = q + 1 + A_SU;
    @(negedge clk);
    a_req_valid = 1'b0;
    if (len != 0) chk(a_busy, "R10 busy after accept", 32'(a_busy), 32'd1);
    seen = a_done;
    dc = cyc;
    if (intrude && !seen) begin
      @(negedge clk);
      a_req_valid = 1'b1; a_req_rd = !rd; a_req_chan = 16'hDEAD; a_req_len = 12'd4;
      @(negedge clk);
      a_req_valid = 1'b0;
    end
    for (int k = 0; k < 3000 && !seen; k++) begin
      @(negedge clk);
      if (a_done) begin seen = 1'b1; dc = cyc; end
    end
    chk(seen, "R9 done seen", 32'(seen), 32'd1);
    if (len == 0) chk(dc == q + 1, "R8 done edge", 32'(dc), 32'(q + 1));
    else chk(dc == last_drop + 3, "R9 done edge", 32'(dc), 32'(last_drop + 3));
    chk(!a_busy, "R9 busy low with done", 32'(a_busy), 32'd0);
    @(negedge clk);
    chk(!a_done, "R9 done one cycle", 32'(a_done), 32'd0);
    chk(words == exp_w, "R7 word count", 32'(words), 32'(exp_w));
    if (rd) chk(rd_cnt == exp_w, "R6 stored words", 32'(rd_cnt), 32'(exp_w));
  endtask

  // rd, chan, len, ack latency high, ack latency low, expected words
  localparam logic [44:0] VEC [0:5] = '{
    {1'b0, 16'h1234, 12'd4,  4'd0, 4'd0, 8'd1},
    {1'b0, 16'hABCD, 12'd13, 4'd3, 4'd1, 8'd4},
    {1'b1, 16'h0042, 12'd8,  4'd1, 4'd4, 8'd2},
    {1'b1, 16'hFFFF, 12'd1,  4'd0, 4'd2, 8'd1},
    {1'b0, 16'h0000, 12'd7,  4'd5, 4'd0, 8'd2},
    {1'b1, 16'h8001, 12'd12, 4'd2, 4'd2, 8'd3}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!a_ready && !a_doe && !a_busy && !a_done && !a_we && a_addr == 0, "R1 reset outputs",
        {27'd0, a_ready, a_doe, a_busy, a_done, a_we}, 32'd0);
    chk(!b_ready && !b_busy && !b_done && b_addr == 0, "R1 reset clamp copy",
        {29'd0, b_ready, b_busy, b_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!a_ready && !a_busy && a_addr == 0, "R1 after reset", {30'd0, a_ready, a_busy}, 32'd0);

    for (int i = 0; i < 6; i++) begin
      logic [44:0] v;
      v = VEC[i];
      run_msg(v[44], v[43:28], v[27:16], int'(v[15:12]), int'(v[11:8]), int'(v[7:0]), 1'b0);
    end

    // R8 zero-length message
    run_msg(1'b0, 16'h5555, 12'd0, 0, 0, 0, 1'b0);
    begin
      bit any_rise;
      any_rise = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (a_ready || a_busy) any_rise = 1;
      end
      chk(!any_rise, "R8 no handshake for zero length", 32'(any_rise), 32'd0);
    end

    // R10 request while busy is ignored
    run_msg(1'b0, 16'h3C3C, 12'd8, 1, 1, 2, 1'b1);
    begin
      bit extra;
      extra = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (a_ready || a_busy) extra = 1;
      end
      chk(!extra, "R10 no extra transfer", 32'(extra), 32'd0);
      chk(words == 2, "R10 word count unchanged", 32'(words), 32'd2);
    end

    // R4 clamped timing on the second copy
    begin
      int q, n;
      @(negedge clk);
      b_req_valid = 1'b1;
      q = cyc;
      @(negedge clk);
      b_req_valid = 1'b0;
      for (int k = 0; k < 100 && !b_ready; k++) @(negedge clk);
      chk(cyc == q + 1 + B_SU_EFF, "R4 setup clamped up", 32'(cyc), 32'(q + 1 + B_SU_EFF));
      chk(b_doe && b_dout == {16'hB0B0, 16'h0}, "R5 clamp copy word", b_dout, {16'hB0B0, 16'h0});
      b_ack = 1'b1;
      n = cyc;
      for (int k = 0; k < 100 && b_ready; k++) @(negedge clk);
      chk(cyc == n + 3 + B_HD_EFF, "R4 hold clamped down", 32'(cyc), 32'(n + 3 + B_HD_EFF));
      b_ack = 1'b0;
      n = cyc;
      for (int k = 0; k < 100 && !b_done; k++) @(negedge clk);
      chk(cyc == n + 3, "R9 clamp copy done", 32'(cyc), 32'(n + 3));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule